// File: doc/BRIEF.md
# Flash Program/Erase Write Controller

This block sits between the data-space write port of an 8-bit processor and a non-volatile byte array, here modelled as registers. Two mode bits and a global enable bit decide where an ordinary data-space write goes. It can go to a separate scratch RAM, or it can program or erase the non-volatile array. Programming can only clear bits: the new byte is the old byte ANDed with the written value. A page erase is the only way to set bits back to one, and it forces every byte of a 512-byte page to 0xFF.

Each array operation runs on an internal cycle counter. Program time and erase time are separate parameters. While an operation runs, the processor is held by a stall output, so software never has to poll for completion. Interrupt requests that arrive during the operation are captured and held. Once the operation ends, they are released one per cycle, lowest index first. Data-space reads always come from the scratch RAM. The array is read only through a separate code-read port with one cycle of latency.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset, `stall_o`, `err_o` and `irq_o` are 0, all mode and enable bits are 0, and every array byte reads back as 0xFF on the code-read port.
- R2: When the redirect bit (`mode_wdata[0]`) is 0, a data-space write stores its byte in scratch RAM at the low address bits and leaves the array unchanged.
- R3: With the enable bit (`gen_wdata[0]`) at 1, the redirect bit at 1 and the erase bit (`mode_wdata[1]`) at 0, a write programs the addressed array byte to (old AND data).
- R4: With the enable, redirect and erase bits all at 1, a write to any address erases the page that address falls in, and the written data is ignored. Every byte of that page becomes 0xFF, and bytes in other pages keep their values.
- R5: With the enable bit at 0, a write with redirect at 1 changes neither the array nor scratch RAM and does not stall. A write with redirect at 0 still goes to scratch RAM.
- R6: `stall_o` rises in the cycle after a triggering write. It stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase.
- R7: A data-space read returns the registered scratch RAM byte one cycle after `xr_addr` is presented, whatever state the redirect bit is in.
- R8: While idle with nothing held, `irq_o` equals `irq_i` in the same cycle. While stalled, `irq_o` is 0 and requests are held. After the stall ends, held requests appear one per cycle as single bits, lowest index first.
- R9: A data-space write seen while stalled sets `err_o` for the next cycle and is discarded.
- R10: `cr_data` presents the array byte at `cr_addr` one cycle after the address is applied.
- R11: The redirect bit stays set across any number of operations until it is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | Bit 0 redirect, bit 1 erase enable |
| gen_we | input | 1 | Write strobe for the global enable |
| gen_wdata | input | 1 | Global program/erase enable |
| xw_en | input | 1 | Data-space write strobe |
| xw_addr | input | FA_W | Data-space write address |
| xw_data | input | 8 | Data-space write byte |
| xr_addr | input | SA_W | Data-space read address |
| xr_data | output | 8 | Scratch RAM read byte, one cycle latency |
| cr_addr | input | FA_W | Code-read address |
| cr_data | output | 8 | Array read byte, one cycle latency |
| irq_i | input | NUM_IRQ | Interrupt request pulses |
| irq_o | output | NUM_IRQ | Interrupt requests released to the processor |
| stall_o | output | 1 | Processor stall during an operation |
| err_o | output | 1 | Write-while-busy flag |

## Verification
Code-read and data-read results are due exactly one cycle after their address is driven. Each read pushes its expected byte into a queue tagged with the cycle it is due, and the monitor compares only when the cycle count reaches that tag. The stall and error flags are sampled on the falling edge straight after the triggering write, and the stall length is counted edge by edge until the flag drops. Held interrupts are checked on successive falling edges starting with the first edge that shows the stall low.

// File: rtl/flwc_pkg.sv
package flwc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  typedef struct packed {
    logic erase_en;
    logic redirect;
  } mode_t;
endpackage

// File: rtl/flwc_seq.sv
module flwc_seq
  import flwc_pkg::*;
#(
  parameter int FA_W      = 10,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_prog_i,
  input  logic            start_erase_i,
  input  logic            xw_en_i,
  input  logic [FA_W-1:0] addr_i,
  input  logic [7:0]      data_i,
  output logic            busy_o,
  output logic [FA_W-1:0] op_addr_o,
  output logic [7:0]      op_data_o,
  output logic            commit_prog_o,
  output logic            commit_erase_o,
  output logic            err_o
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic            busy_q, busy_d;
  op_e             op_q, op_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [FA_W-1:0] addr_q, addr_d;
  logic [7:0]      data_q, data_d;
  logic            err_q, err_d;

  always_comb begin
    busy_d         = busy_q;
    op_d           = op_q;
    cnt_d          = cnt_q;
    addr_d         = addr_q;
    data_d         = data_q;
    commit_prog_o  = 1'b0;
    commit_erase_o = 1'b0;
    err_d          = xw_en_i & busy_q;
    if (!busy_q) begin
      if (start_prog_i) begin
        busy_d = 1'b1;
        op_d   = OP_PROG;
        cnt_d  = CW'(PROG_CYC - 1);
        addr_d = addr_i;
        data_d = data_i;
      end else if (start_erase_i) begin
        busy_d = 1'b1;
        op_d   = OP_ERASE;
        cnt_d  = CW'(ERASE_CYC - 1);
        addr_d = addr_i;
        data_d = data_i;
      end
    end else if (cnt_q == '0) begin
      busy_d         = 1'b0;
      op_d           = OP_NONE;
      commit_prog_o  = (op_q == OP_PROG);
      commit_erase_o = (op_q == OP_ERASE);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
      err_q  <= err_d;
    end
  end

  assign busy_o    = busy_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
  assign err_o     = err_q;

  // R6
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_prog_i || start_erase_i));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/flwc_array.sv
module flwc_array #(
  parameter int FA_W       = 10,
  parameter int PAGE_BYTES = 512,
  parameter int NUM_PAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_i,
  input  logic            erase_i,
  input  logic [FA_W-1:0] addr_i,
  input  logic [7:0]      data_i,
  input  logic [FA_W-1:0] cr_addr_i,
  output logic [7:0]      cr_data_o
);
  localparam int NB   = PAGE_BYTES * NUM_PAGES;
  localparam int PG_W = $clog2(PAGE_BYTES);

  logic [7:0] mem_q [NB];
  logic [7:0] mem_d [NB];
  logic [7:0] rd_q;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      mem_d[i] = mem_q[i];
      if (erase_i && ((FA_W'(i) >> PG_W) == (addr_i >> PG_W)))
        mem_d[i] = 8'hFF;
      else if (prog_i && (addr_i == FA_W'(i)))
        mem_d[i] = mem_q[i] & data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= 8'hFF;
    end else if (prog_i || erase_i) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= mem_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'hFF;
    else        rd_q <= mem_q[cr_addr_i];
  end

  assign cr_data_o = rd_q;

  // R3
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_i |=> mem_q[$past(addr_i)] == ($past(mem_q[addr_i]) & $past(data_i)));
  // R4
  erase_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> mem_q[$past(addr_i)] == 8'hFF);
endmodule

// File: rtl/flwc_irq_hold.sv
module flwc_irq_hold #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  logic [NUM_IRQ-1:0] pend_q, pend_d;
  logic [NUM_IRQ-1:0] grant;
  logic               holding;

  assign holding = |pend_q;

  // lowest set bit wins
  always_comb begin
    grant = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend_q[i]) grant = NUM_IRQ'(1) << i;
    end
  end

  always_comb begin
    if (busy_i)       irq_o = '0;
    else if (holding) irq_o = grant;
    else              irq_o = irq_i;
  end

  always_comb begin
    pend_d = pend_q;
    if (busy_i)       pend_d = pend_q | irq_i;
    else if (holding) pend_d = (pend_q & ~grant) | irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> irq_o == '0);
  // R8
  irq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && holding) |-> $onehot(irq_o));
endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flwc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int NUM_PAGES  = 2,
  parameter int SCR_DEPTH  = 256,
  parameter int PROG_CYC   = 16,
  parameter int ERASE_CYC  = 128,
  parameter int NUM_IRQ    = 4,
  localparam int FA_W      = $clog2(PAGE_BYTES * NUM_PAGES),
  localparam int SA_W      = $clog2(SCR_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_we,
  input  logic [1:0]         mode_wdata,
  input  logic               gen_we,
  input  logic               gen_wdata,
  input  logic               xw_en,
  input  logic [FA_W-1:0]    xw_addr,
  input  logic [7:0]         xw_data,
  input  logic [SA_W-1:0]    xr_addr,
  output logic [7:0]         xr_data,
  input  logic [FA_W-1:0]    cr_addr,
  output logic [7:0]         cr_data,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               stall_o,
  output logic               err_o
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  mode_t mode_q, mode_d;
  logic  user_en_q, user_en_d;

  always_comb begin
    mode_d    = mode_q;
    user_en_d = user_en_q;
    if (mode_we) mode_d    = mode_t'(mode_wdata);
    if (gen_we)  user_en_d = gen_wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q    <= '0;
      user_en_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      user_en_q <= user_en_d;
    end
  end

  logic busy;
  logic flash_hit, start_prog, start_erase, scr_we;

  always_comb begin
    flash_hit   = xw_en & ~busy & mode_q.redirect & user_en_q;
    start_prog  = flash_hit & ~mode_q.erase_en;
    start_erase = flash_hit &  mode_q.erase_en;
    scr_we      = xw_en & ~busy & ~mode_q.redirect;
  end

  logic [7:0] scr_mem [SCR_DEPTH];
  logic [7:0] xr_q;

  always_ff @(posedge clk) begin
    if (scr_we) scr_mem[xw_addr[SA_W-1:0]] <= xw_data;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) xr_q <= '0;
    else         xr_q <= scr_mem[xr_addr];
  end
  assign xr_data = xr_q;

  logic [FA_W-1:0] op_addr;
  logic [7:0]      op_data;
  logic            commit_prog, commit_erase;

  flwc_seq #(
    .FA_W      (FA_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_sn),
    .start_prog_i   (start_prog),
    .start_erase_i  (start_erase),
    .xw_en_i        (xw_en),
    .addr_i         (xw_addr),
    .data_i         (xw_data),
    .busy_o         (busy),
    .op_addr_o      (op_addr),
    .op_data_o      (op_data),
    .commit_prog_o  (commit_prog),
    .commit_erase_o (commit_erase),
    .err_o          (err_o)
  );

  flwc_array #(
    .FA_W       (FA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_sn),
    .prog_i    (commit_prog),
    .erase_i   (commit_erase),
    .addr_i    (op_addr),
    .data_i    (op_data),
    .cr_addr_i (cr_addr),
    .cr_data_o (cr_data)
  );

  flwc_irq_hold #(
    .NUM_IRQ (NUM_IRQ)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_sn),
    .busy_i (busy),
    .irq_i  (irq_i),
    .irq_o  (irq_o)
  );

  assign stall_o = busy;

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (xw_en && stall_o) |=> err_o);
  // R5
  user_lock_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (xw_en && !stall_o && !user_en_q && mode_q.redirect) |=> !stall_o);
  // R2
  scratch_route_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (xw_en && !stall_o && !mode_q.redirect) |=> !stall_o);
endmodule

// File: tb/flash_wr_ctrl_bench.sv
module flash_wr_ctrl_bench;
  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 128;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_we = 1'b0, gen_we = 1'b0, gen_wdata = 1'b0, xw_en = 1'b0;
  logic [1:0] mode_wdata = '0;
  logic [9:0] xw_addr = '0, cr_addr = '0;
  logic [7:0] xw_data = '0, xr_data, cr_data;
  logic [7:0] xr_addr = '0;
  logic [3:0] irq_i = '0, irq_o;
  logic       stall_o, err_o;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_wr_ctrl u_flash_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .gen_we(gen_we), .gen_wdata(gen_wdata), .xw_en(xw_en), .xw_addr(xw_addr),
    .xw_data(xw_data), .xr_addr(xr_addr), .xr_data(xr_data), .cr_addr(cr_addr),
    .cr_data(cr_data), .irq_i(irq_i), .irq_o(irq_o), .stall_o(stall_o), .err_o(err_o)
  );

  typedef struct {
    int         due;
    bit         code;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  item_t it;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each queued read in the cycle it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      check(it.req, it.code ? cr_data : xr_data, it.exp);
    end
  end

  task automatic cr_exp(input logic [9:0] a, input logic [7:0] e, input string req);
    item_t n;
    cr_addr = a;
    n.due = cyc + 1; n.code = 1'b1; n.exp = e; n.req = req;
    q.push_back(n);
    @(negedge clk);
  endtask

  task automatic xr_exp(input logic [7:0] a, input logic [7:0] e, input string req);
    item_t n;
    xr_addr = a;
    n.due = cyc + 1; n.code = 1'b0; n.exp = e; n.req = req;
    q.push_back(n);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] v);
    mode_we = 1'b1; mode_wdata = v; @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic set_gen(input logic v);
    gen_we = 1'b1; gen_wdata = v; @(negedge clk); gen_we = 1'b0;
  endtask

  task automatic xw(input logic [9:0] a, input logic [7:0] d);
    xw_en = 1'b1; xw_addr = a; xw_data = d; @(negedge clk); xw_en = 1'b0;
  endtask

  task automatic stall_len(output int n);
    n = 0;
    while (stall_o) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 stall", stall_o, 0);
    check("R1 err", err_o, 0);
    check("R1 irq", irq_o, 0);
    cr_exp(10'd0, 8'hFF, "R1 erased byte 0");
    cr_exp(10'd5, 8'hFF, "R10 erased byte 5");
    cr_exp(10'd1023, 8'hFF, "R1 erased byte 1023");
    @(negedge clk);

    // scratch routing
    xw(10'd3, 8'h5A);
    check("R2 no stall", stall_o, 0);
    xr_exp(8'd3, 8'h5A, "R2 scratch write");
    cr_exp(10'd3, 8'hFF, "R2 array untouched");

    // enable clear, redirect set: ignored
    set_mode(2'b01);
    xw(10'd3, 8'h00);
    check("R5 no stall when locked", stall_o, 0);
    xr_exp(8'd3, 8'h5A, "R5 scratch untouched");
    cr_exp(10'd3, 8'hFF, "R5 array untouched");
    set_mode(2'b00);
    xw(10'd4, 8'h77);
    xr_exp(8'd4, 8'h77, "R5 falls through to scratch");

    // program
    set_gen(1'b1);
    set_mode(2'b01);
    xw(10'd3, 8'hF0);
    stall_len(n);
    check("R6 program stall length", n, PROG_CYC);
    cr_exp(10'd3, 8'hF0, "R3 program");
    xr_exp(8'd3, 8'h5A, "R7 data read hits scratch");
    xw(10'd3, 8'h3C);
    check("R11 redirect still set", stall_o, 1);
    stall_len(n);
    cr_exp(10'd3, 8'h30, "R3 program ANDs");
    xw(10'd600, 8'hA5);
    stall_len(n);
    cr_exp(10'd600, 8'hA5, "R11 third program");

    // interrupts and error
    irq_i = 4'b0101; #1;
    check("R8 pass-through", irq_o, 4'b0101);
    @(negedge clk); irq_i = 4'b0000;
    xw(10'd10, 8'h0F);
    check("R6 stall rises next cycle", stall_o, 1);
    irq_i = 4'b1010; #1;
    check("R8 quiet while busy", irq_o, 0);
    @(negedge clk); irq_i = 4'b0100; #1;
    check("R8 quiet while busy 2", irq_o, 0);
    @(negedge clk); irq_i = 4'b0000;
    xw(10'd10, 8'h00);
    check("R9 err flag", err_o, 1);
    stall_len(n);
    check("R8 release 1", irq_o, 4'b0010);
    @(negedge clk);
    check("R8 release 2", irq_o, 4'b0100);
    @(negedge clk);
    check("R8 release 3", irq_o, 4'b1000);
    @(negedge clk);
    check("R8 drained", irq_o, 4'b0000);
    cr_exp(10'd10, 8'h0F, "R9 busy write discarded");

    // erase second page
    set_mode(2'b11);
    xw(10'd520, 8'h00);
    stall_len(n);
    check("R6 erase stall length", n, ERASE_CYC);
    cr_exp(10'd600, 8'hFF, "R4 erased 600");
    cr_exp(10'd520, 8'hFF, "R4 erased 520");
    cr_exp(10'd1023, 8'hFF, "R4 erased 1023");
    cr_exp(10'd3, 8'h30, "R4 other page kept");
    cr_exp(10'd10, 8'h0F, "R4 other page kept 10");

    set_mode(2'b01);
    xw(10'd600, 8'h12);
    stall_len(n);
    cr_exp(10'd600, 8'h12, "R4 reprogram after erase");
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule